// File: doc/BRIEF.md
# DMA Channel Request Enable Gate

This block keeps one request-enable flag for each of a set of DMA channels (eight by default) and uses those flags to qualify each channel's hardware service request. A channel's hardware request reaches the arbiter only while that channel's enable flag is on. Requests raised by software, or by a link from another channel, go through whatever the flag holds.

Software changes the flags through three write ports. The first replaces the whole bitmap. The second is a set alias that turns on one channel's flag. The third is a clear alias that turns it off. The aliases let one channel be changed without a read-modify-write of the bitmap.

Each alias word holds a channel number in its low bits. Bit 6 widens the write to every channel, and bit 7 cancels the write. All enable writes take effect at the next rising clock edge. The gated request outputs are combinational from the request inputs and the current flags. Every pin is a plain control level, because no data stream crosses this block and so there is no back-pressure.

Top module: `dreq_enable_gate`

## Requirements
- R1: The block holds one enable flag per channel, and `en_state[i]` reads back the current flag of channel i.
- R2: When `map_we` is high at a rising edge, all enable flags take the value of `map_data` after that edge.
- R3: When `set_we` is high and `set_data` bits 7 and 6 are both 0, the flag of the channel numbered by `set_data[2:0]` turns on after the edge, and every other flag keeps its value.
- R4: When `clr_we` is high and `clr_data` bits 7 and 6 are both 0, the flag of the channel numbered by `clr_data[2:0]` turns off after the edge, and every other flag keeps its value.
- R5: An alias word with bit 6 set and bit 7 clear acts on all channels: a set turns every flag on, and a clear turns every flag off.
- R6: An alias word with bit 7 set leaves every flag unchanged, whatever its other bits hold.
- R7: When writes coincide, a bitmap write overrides both aliases. Without a bitmap write, the set is applied first and the clear second, so the clear wins on any channel both of them name.
- R8: With no software or linked request on a channel, `svc_req[i]` equals `hw_req[i] & en_state[i]` in the same cycle.
- R9: A high `sw_req[i]` or `link_req[i]` drives `svc_req[i]` high in the same cycle, whatever the state of the enable flag.
- R10: While `rst_n` is low, and on the first cycle after it, every enable flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_we | input | 1 | Bitmap write strobe |
| map_data | input | 8 | New enable bitmap, bit i for channel i |
| set_we | input | 1 | Set-alias write strobe |
| set_data | input | 8 | Set-alias word: [2:0] channel, 6 all channels, 7 ignore |
| clr_we | input | 1 | Clear-alias write strobe |
| clr_data | input | 8 | Clear-alias word, same layout as the set alias |
| hw_req | input | 8 | Hardware request per channel |
| sw_req | input | 8 | Software-initiated request per channel |
| link_req | input | 8 | Linked-channel request per channel |
| en_state | output | 8 | Current enable bitmap |
| svc_req | output | 8 | Qualified service request per channel |

## Verification
The assertions take the write strobes and request inputs to be clean levels that are sampled at the rising edge. They take alias words to mean only what bits 7, 6 and [2:0] say, and treat bits 5:3 as don't-care. The bench drives every input at the falling edge, so the inputs are always settled before the sampling edge. Random alias words fill bits 5:3 with noise and set bits 6 and 7 only part of the time, so the assertions see each decode case and the noise has no effect on the outcome.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  // Alias write word layout
  localparam int ALIAS_W  = 8;
  localparam int ALL_POS  = 6;
  localparam int SKIP_POS = 7;

  typedef logic [ALIAS_W-1:0] alias_word_t;
endpackage

// File: rtl/dreq_alias_decode.sv
module dreq_alias_decode
  import dreq_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic            we,
  input  alias_word_t     word,
  output logic [NCH-1:0]  mask
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  logic          act;
  logic          all_ch;
  logic [CW-1:0] sel;
  logic          unused_mid;

  assign act        = we & ~word[SKIP_POS];
  assign all_ch     = word[ALL_POS];
  assign sel        = word[CW-1:0];
  assign unused_mid = ^word[ALL_POS-1:CW];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign mask[i] = act & (all_ch | (sel == CW'(i)));
  end
endmodule

// File: rtl/dreq_enable_reg.sv
module dreq_enable_reg #(
  parameter int NCH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            map_we,
  input  logic [NCH-1:0]  map_data,
  input  logic [NCH-1:0]  set_mask,
  input  logic [NCH-1:0]  clr_mask,
  output logic [NCH-1:0]  en_q
);
  logic [NCH-1:0] after_set;
  logic [NCH-1:0] en_d;

  // Set is applied first, then clear; a bitmap write overrides both
  always_comb begin
    after_set = en_q | set_mask;
    en_d      = map_we ? map_data : (after_set & ~clr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end
endmodule

// File: rtl/dreq_gate.sv
module dreq_gate #(
  parameter int NCH = 8
) (
  input  logic [NCH-1:0] en,
  input  logic [NCH-1:0] hw_req,
  input  logic [NCH-1:0] sw_req,
  input  logic [NCH-1:0] link_req,
  output logic [NCH-1:0] svc_req
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign svc_req[i] = (hw_req[i] & en[i]) | sw_req[i] | link_req[i];
  end
endmodule

// File: rtl/dreq_enable_gate.sv
module dreq_enable_gate
  import dreq_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               map_we,
  input  logic [NCH-1:0]     map_data,
  input  logic               set_we,
  input  logic [ALIAS_W-1:0] set_data,
  input  logic               clr_we,
  input  logic [ALIAS_W-1:0] clr_data,
  input  logic [NCH-1:0]     hw_req,
  input  logic [NCH-1:0]     sw_req,
  input  logic [NCH-1:0]     link_req,
  output logic [NCH-1:0]     en_state,
  output logic [NCH-1:0]     svc_req
);
  logic [NCH-1:0] set_mask;
  logic [NCH-1:0] clr_mask;
  logic [NCH-1:0] en_q;

  dreq_alias_decode #(.NCH(NCH)) u_set_dec (
    .we(set_we), .word(set_data), .mask(set_mask)
  );

  dreq_alias_decode #(.NCH(NCH)) u_clr_dec (
    .we(clr_we), .word(clr_data), .mask(clr_mask)
  );

  dreq_enable_reg #(.NCH(NCH)) u_en (
    .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_data(map_data),
    .set_mask(set_mask), .clr_mask(clr_mask), .en_q(en_q)
  );

  dreq_gate #(.NCH(NCH)) u_gate (
    .en(en_q), .hw_req(hw_req), .sw_req(sw_req), .link_req(link_req),
    .svc_req(svc_req)
  );

  assign en_state = en_q;
endmodule

// File: rtl/dreq_enable_gate_checker.sv
module dreq_enable_gate_checker
  import dreq_pkg::*;
#(
  parameter int NCH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               map_we,
  input logic [NCH-1:0]     map_data,
  input logic               set_we,
  input logic [ALIAS_W-1:0] set_data,
  input logic               clr_we,
  input logic [ALIAS_W-1:0] clr_data,
  input logic [NCH-1:0]     hw_req,
  input logic [NCH-1:0]     sw_req,
  input logic [NCH-1:0]     link_req,
  input logic [NCH-1:0]     en_state,
  input logic [NCH-1:0]     svc_req
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  // R2: a bitmap write lands verbatim
  p_map_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    map_we |=> en_state == $past(map_data));

  // R3: a lone single-channel set turns that channel on
  p_set_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !map_we && !clr_we && !set_data[SKIP_POS] && !set_data[ALL_POS])
    |=> en_state[$past(set_data[CW-1:0])]);

  // R4: a lone single-channel clear turns that channel off
  p_clr_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !map_we && !set_we && !clr_data[SKIP_POS] && !clr_data[ALL_POS])
    |=> !en_state[$past(clr_data[CW-1:0])]);

  // R5: broadcast clear empties the bitmap
  p_clr_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !map_we && !clr_data[SKIP_POS] && clr_data[ALL_POS])
    |=> en_state == '0);

  // R6: ignored alias words change nothing
  p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!map_we && (!set_we || set_data[SKIP_POS]) && (!clr_we || clr_data[SKIP_POS]))
    |=> $stable(en_state));

  // R8: no service request without a qualified source
  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_req & ~sw_req & ~link_req & ~(hw_req & en_state)) == '0);

  // R9: software and linked requests always pass
  p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_req | link_req) & ~svc_req) == '0);

  // R10: enables read zero coming out of reset
  p_reset_r10: assert property (@(posedge clk)
    !rst_n |=> en_state == '0);
endmodule

bind dreq_enable_gate dreq_enable_gate_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_data(map_data),
  .set_we(set_we), .set_data(set_data), .clr_we(clr_we), .clr_data(clr_data),
  .hw_req(hw_req), .sw_req(sw_req), .link_req(link_req),
  .en_state(en_state), .svc_req(svc_req)
);

// File: tb/dreq_enable_gate_bench.sv
module dreq_enable_gate_bench;
  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           map_we = 1'b0;
  logic [NCH-1:0] map_data = '0;
  logic           set_we = 1'b0;
  logic [7:0]     set_data = '0;
  logic           clr_we = 1'b0;
  logic [7:0]     clr_data = '0;
  logic [NCH-1:0] hw_req = '0;
  logic [NCH-1:0] sw_req = '0;
  logic [NCH-1:0] link_req = '0;
  logic [NCH-1:0] en_state;
  logic [NCH-1:0] svc_req;

  int total = 0;
  int bad = 0;
  logic [NCH-1:0] model = '0;

  always #10 clk = ~clk;  // 50 MHz

  dreq_enable_gate #(.NCH(NCH)) u_dreq_enable_gate (
    .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_data(map_data),
    .set_we(set_we), .set_data(set_data), .clr_we(clr_we), .clr_data(clr_data),
    .hw_req(hw_req), .sw_req(sw_req), .link_req(link_req),
    .en_state(en_state), .svc_req(svc_req)
  );

  function automatic logic [NCH-1:0] alias_mask(input logic we, input logic [7:0] w);
    if (!we || w[7]) return '0;
    if (w[6]) return '1;
    return NCH'(1) << w[2:0];
  endfunction

  function automatic logic [NCH-1:0] next_en(input logic [NCH-1:0] cur);
    if (map_we) return map_data;
    return (cur | alias_mask(set_we, set_data)) & ~alias_mask(clr_we, clr_data);
  endfunction

  task automatic check(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at falling edge, check outputs, advance one clock
  task automatic cycle(input string req_en, input string req_svc);
    check(req_en, en_state, model);
    #1;
    check(req_svc, svc_req, (hw_req & model) | sw_req | link_req);
    model = next_en(model);
    @(negedge clk);
  endtask

  task automatic idle();
    map_we = 0; set_we = 0; clr_we = 0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R10", en_state, '0);
    hw_req = '1;
    #1 check("R8", svc_req, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", en_state, '0);

    // R2 bitmap write
    map_we = 1; map_data = 8'hA5; cycle("R1", "R8"); idle();
    check("R2", en_state, 8'hA5);
    // R3 single set
    set_we = 1; set_data = 8'h03; cycle("R2", "R8"); idle();
    check("R3", en_state, 8'hAD);
    // R4 single clear, noise in bits 5:3
    clr_we = 1; clr_data = 8'h38; cycle("R3", "R8"); idle();
    check("R4", en_state, 8'hAC);
    // R6 ignored words, even with bit 6 set
    set_we = 1; set_data = 8'hC1; clr_we = 1; clr_data = 8'hC2; cycle("R4", "R8"); idle();
    check("R6", en_state, 8'hAC);
    // R5 broadcast set
    set_we = 1; set_data = 8'h40; cycle("R6", "R8"); idle();
    check("R5", en_state, 8'hFF);
    // R7 set and clear same channel: clear wins
    set_we = 1; set_data = 8'h05; clr_we = 1; clr_data = 8'h05; cycle("R5", "R8"); idle();
    check("R7", en_state, 8'hDF);
    // R7 bitmap write beats both aliases
    map_we = 1; map_data = 8'h0F; set_we = 1; set_data = 8'h07; clr_we = 1; clr_data = 8'h00;
    cycle("R7", "R8"); idle();
    check("R7", en_state, 8'h0F);
    // R5 broadcast clear
    clr_we = 1; clr_data = 8'h40; cycle("R7", "R8"); idle();
    check("R5", en_state, 8'h00);
    // R9 bypass with all enables off
    hw_req = '1; sw_req = 8'h81; link_req = 8'h18;
    #1 check("R9", svc_req, 8'h99);
    @(negedge clk);
    sw_req = '0; link_req = '0;

    // Random phase
    for (int n = 0; n < 600; n++) begin
      map_we   = ($urandom_range(0, 7) == 0);
      map_data = NCH'($urandom);
      set_we   = $urandom_range(0, 1) == 1;
      set_data = 8'($urandom) & ($urandom_range(0, 3) == 0 ? 8'hFF : 8'h3F);
      clr_we   = $urandom_range(0, 1) == 1;
      clr_data = 8'($urandom) & ($urandom_range(0, 3) == 0 ? 8'hFF : 8'h3F);
      hw_req   = NCH'($urandom);
      sw_req   = NCH'($urandom) & NCH'($urandom);
      link_req = NCH'($urandom) & NCH'($urandom);
      cycle("R7", "R9");
    end
    idle();
    check("R1", en_state, model);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule